// File: doc/BRIEF.md
# Key-Unlocked Protected Register File

This block is a small system-control register file in which the device-configuration state is guarded by a one-shot software unlock. A bus master first writes the key byte 0xAA to the lock register. The unlock then covers exactly one later bus write. If that write targets a protected register, the write lands and the unlock is used up. Any other write order is discarded. Protected writes made without an unlock leave the register unchanged and raise a sticky violation flag.

The configuration word drives the chip's mux and enable logic directly through `cfg_out`. One bit of the word is the software-reset bit. Software starts a reset by setting that bit and then clearing it, and the block answers the clearing write with a single-cycle pulse on `swrst_pulse`.

A read-only system-information register carries a revision number. Software extracts it by masking and shifting.

The unlock is tracked by a two-state machine:
- `ST_LOCKED` is the state after reset. The transition *arm* (a write of the key to the lock register) moves it to `ST_ARMED`.
- In `ST_ARMED`, the transition *rearm* (another key write) keeps the state.
- The transition *consume* (any other write, protected or not) returns the machine to `ST_LOCKED`.
- Reads never move the machine.

Register map, with the 3-bit word address on `bus_addr`:

| Address | Register | Access | Behaviour |
|---------|----------|--------|-----------|
| 0 | lock | read/write | Write the key to arm. A read returns 1 in bit 0 while armed. |
| 1 | config | protected write, read | A write replaces the whole word. |
| 2 | config-set | protected, write-only | Written 1 bits are ORed into config. |
| 3 | config-clear | protected, write-only | Written 1 bits are cleared in config. |
| 4 | info | read-only | Revision number. |
| 5 | status | read/write | Bit 0 is the sticky violation flag. |

Top module: `prf_regfile`

## Requirements
- R1: After reset, `cfg_out` and config read back as CFG_RESET (0), the lock read returns 0, the status read returns 0 and `swrst_pulse` is low.
- R2: A write of exactly 32'h0000_00AA to address 0 arms the unlock. While armed, a read of address 0 returns 32'h1; otherwise it returns 0.
- R3: A protected write (address 1, 2 or 3) that is the first write after an arming write takes effect, and the unlock is consumed by it.
- R4: A protected write while not armed leaves config unchanged and sets status bit 0.
- R5: Any write other than a key write cancels a pending unlock. This covers non-key data written to address 0 and writes to addresses 4 to 7.
- R6: Address 1 replaces config, address 2 ORs the written data into config, and address 3 clears the written 1 bits. Reads of addresses 2 and 3 return 0.
- R7: A read of address 4 returns REVISION (8'h02) in bits [15:8] and 0 elsewhere. Writes to address 4 change nothing.
- R8: `swrst_pulse` is high for exactly one cycle, the cycle after an accepted write takes config bit 31 from 1 to 0. It stays low for every other write.
- R9: Status bit 0 stays set until a write to address 5 with bit 0 at 1 clears it. A write to address 5 with bit 0 at 0 leaves it unchanged.
- R10: Addresses 6 and 7 read 0, and writes to them change no register.
- R11: `cfg_out` equals the value read from address 1 at all times.
- R12: Repeated key writes keep the unlock armed, so a protected write after two key writes still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Word address for the read and the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `bus_addr` |
| cfg_out | output | 32 | Current configuration word |
| swrst_pulse | output | 1 | One-cycle software reset pulse |

## Verification
The bench sweeps every address as the write that follows either an arming write or no arming write, using data patterns that toggle the reset bit and include the key value. After each write it compares every readable register against an arithmetic model.

This sweep catches the main classes of faults:
- A design that keeps the unlock open for more than one write lets a second protected write through.
- A design that does not cancel on unprotected writes accepts a late protected write.
- A design that pulses on the rising edge of the reset bit, or holds the pulse longer, miscompares on the pulse check.

Directed steps cover the remaining corners. They confirm that the violation flag survives a zero write and clears only on a one. They confirm that a doubled key write still arms.

// File: rtl/prf_pkg.sv
package prf_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_LOCK = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
    localparam logic [ADDR_W-1:0] A_SET  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_INFO = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_ARMED  = 1'b1
    } lock_state_e;

    function automatic logic is_protected(input logic [ADDR_W-1:0] a);
        return (a == A_CFG) || (a == A_SET) || (a == A_CLR);
    endfunction

endpackage

// File: rtl/prf_unlock_fsm.sv
module prf_unlock_fsm
    import prf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned KEY    = 32'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              armed,
    output logic              grant,
    output logic              deny
);

    lock_state_e state_q, state_d;
    logic        key_hit;
    logic        prot_wr;

    assign key_hit = wr_en && (wr_addr == A_LOCK) && (wr_data == DATA_W'(KEY));
    assign prot_wr = wr_en && is_protected(wr_addr);

    // Next-state logic: arm, rearm and consume.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (key_hit) state_d = ST_ARMED;
            ST_ARMED:  if (wr_en)   state_d = key_hit ? ST_ARMED : ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        armed = 1'b0;
        grant = 1'b0;
        deny  = 1'b0;
        unique case (state_q)
            ST_LOCKED: deny = prot_wr;
            ST_ARMED: begin
                armed = 1'b1;
                grant = prot_wr;
            end
            default: deny = prot_wr;
        endcase
    end

    p_arm_on_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_LOCK && wr_data == DATA_W'(KEY)) |=> armed);

    p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en && wr_addr != A_LOCK) |=> !armed);

endmodule

// File: rtl/prf_devcfg.sv
module prf_devcfg
    import prf_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned RST_BIT   = 31,
    parameter logic [DATA_W-1:0] CFG_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cfg_q,
    output logic              swrst_pulse
);

    logic [DATA_W-1:0] cfg_d;
    logic              pulse_d;

    always_comb begin
        cfg_d = cfg_q;
        if (grant) begin
            unique case (wr_addr)
                A_CFG:   cfg_d = wr_data;
                A_SET:   cfg_d = cfg_q | wr_data;
                A_CLR:   cfg_d = cfg_q & ~wr_data;
                default: cfg_d = cfg_q;
            endcase
        end
    end

    assign pulse_d = grant && cfg_q[RST_BIT] && !cfg_d[RST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= CFG_RESET;
            swrst_pulse <= 1'b0;
        end else begin
            cfg_q       <= cfg_d;
            swrst_pulse <= pulse_d;
        end
    end

    p_change_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q != $past(cfg_q)) |-> $past(grant));

    p_pulse_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_pulse |-> (!cfg_q[RST_BIT] && $past(cfg_q[RST_BIT])));

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_pulse |=> !swrst_pulse);

endmodule

// File: rtl/prf_violation.sv
module prf_violation
    import prf_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deny,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              viol_q
);

    logic clr_hit;

    assign clr_hit = wr_en && (wr_addr == A_STAT) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       viol_q <= 1'b0;
        else if (deny)    viol_q <= 1'b1;
        else if (clr_hit) viol_q <= 1'b0;
    end

    p_set_on_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
        deny |=> viol_q);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_q && !(wr_en && wr_addr == A_STAT && wr_data[0])) |=> viol_q);

endmodule

// File: rtl/prf_regfile.sv
module prf_regfile
    import prf_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned KEY       = 32'hAA,
    parameter int unsigned RST_BIT   = 31,
    parameter int unsigned REV_LSB   = 8,
    parameter int unsigned REV_W     = 8,
    parameter logic [REV_W-1:0]  REVISION  = 8'h02,
    parameter logic [DATA_W-1:0] CFG_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] cfg_out,
    output logic              swrst_pulse
);

    localparam logic [DATA_W-1:0] INFO_WORD =
        DATA_W'(REVISION) << REV_LSB;

    logic armed, grant, deny, viol_q;

    prf_unlock_fsm #(.DATA_W(DATA_W), .KEY(KEY)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (bus_addr),
        .wr_data (wdata),
        .armed   (armed),
        .grant   (grant),
        .deny    (deny)
    );

    prf_devcfg #(.DATA_W(DATA_W), .RST_BIT(RST_BIT), .CFG_RESET(CFG_RESET)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant       (grant),
        .wr_addr     (bus_addr),
        .wr_data     (wdata),
        .cfg_q       (cfg_out),
        .swrst_pulse (swrst_pulse)
    );

    prf_violation #(.DATA_W(DATA_W)) u_viol (
        .clk     (clk),
        .rst_n   (rst_n),
        .deny    (deny),
        .wr_en   (wr_en),
        .wr_addr (bus_addr),
        .wr_data (wdata),
        .viol_q  (viol_q)
    );

    always_comb begin
        rdata = '0;
        case (bus_addr)
            A_LOCK:  rdata[0] = armed;
            A_CFG:   rdata    = cfg_out;
            A_INFO:  rdata    = INFO_WORD;
            A_STAT:  rdata[0] = viol_q;
            default: rdata    = '0;
        endcase
    end

    p_no_grant_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && wr_en && bus_addr == A_CFG) |=> (cfg_out == $past(cfg_out)));

endmodule

// File: tb/test_prf_regfile.sv
`timescale 1ns/100ps
module test_prf_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, cfg_out;
    logic        swrst_pulse;

    int nvec = 0;
    int nmis = 0;

    logic [31:0] exp_cfg = 32'h0;
    bit exp_armed = 0;
    bit exp_viol  = 0;
    bit exp_pulse = 0;

    localparam logic [31:0] INFO_EXP = 32'h0000_0200;

    always #5 clk = ~clk;

    prf_regfile i_prf_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_addr(bus_addr),
        .wdata(wdata), .rdata(rdata), .cfg_out(cfg_out), .swrst_pulse(swrst_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.4;
        d = rdata;
    endtask

    task automatic check_all();
        logic [31:0] d;
        chk("R11 cfg_out", cfg_out, exp_cfg);
        rd(3'd0, d); chk("R2/R5 lock read", d, {31'b0, exp_armed});
        rd(3'd1, d); chk("R3/R6 config read", d, exp_cfg);
        rd(3'd2, d); chk("R6 set reads zero", d, 32'h0);
        rd(3'd3, d); chk("R6 clear reads zero", d, 32'h0);
        rd(3'd4, d); chk("R7 info read", d, INFO_EXP);
        rd(3'd5, d); chk("R9/R4 status read", d, {31'b0, exp_viol});
        rd(3'd6, d); chk("R10 addr6 read", d, 32'h0);
        rd(3'd7, d); chk("R10 addr7 read", d, 32'h0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        logic [31:0] prev;
        bit prot, key;
        prev = exp_cfg;
        key  = (a == 3'd0) && (d == 32'hAA);
        prot = (a == 3'd1) || (a == 3'd2) || (a == 3'd3);
        if (prot) begin
            if (exp_armed) begin
                if (a == 3'd1)      exp_cfg = d;
                else if (a == 3'd2) exp_cfg = exp_cfg | d;
                else                exp_cfg = exp_cfg & ~d;
            end else begin
                exp_viol = 1;
            end
        end
        if (a == 3'd5 && d[0]) exp_viol = 0;
        exp_pulse = prot && exp_armed && prev[31] && !exp_cfg[31];
        exp_armed = key;
        @(negedge clk);
        wr_en = 1'b1; bus_addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 reset pulse after write", {31'b0, swrst_pulse}, {31'b0, exp_pulse});
        @(negedge clk);
        chk("R8 pulse width one cycle", {31'b0, swrst_pulse}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nmis++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin : main
        logic [31:0] pats [3];
        pats[0] = 32'h8000_00F0;
        pats[1] = 32'h0000_0F0F;
        pats[2] = 32'h0000_00AA;

        repeat (3) @(negedge clk);
        chk("R1 pulse at reset", {31'b0, swrst_pulse}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();  // R1 reset state

        // Sweep: every address as the write after an arm or after none.
        for (int p = 0; p < 3; p++) begin
            for (int arm = 0; arm < 2; arm++) begin
                for (int a = 0; a < 8; a++) begin
                    if (arm == 1) wr(3'd0, 32'hAA);
                    wr(3'(a), pats[p]);
                    check_all();
                    // A second protected write must not ride on the same unlock (R3).
                    wr(3'd2, 32'h0000_1000);
                    check_all();
                end
            end
        end

        // R5: a non-key write to the lock register cancels.
        wr(3'd0, 32'hAA); wr(3'd0, 32'h55); wr(3'd1, 32'h1234_5678); check_all();
        // R5/R7: a write to info cancels and changes nothing.
        wr(3'd0, 32'hAA); wr(3'd4, 32'hFFFF_FFFF); wr(3'd1, 32'h0); check_all();
        // R12: a double key still arms.
        wr(3'd0, 32'hAA); wr(3'd0, 32'hAA); check_all();
        wr(3'd1, 32'h8000_0001); check_all();
        // R8: clearing bit 31 through config-clear gives the pulse.
        wr(3'd0, 32'hAA); wr(3'd3, 32'h8000_0000); check_all();
        // R9: a zero write keeps the flag, a one write clears it.
        wr(3'd1, 32'h0); check_all();
        wr(3'd5, 32'h0); check_all();
        wr(3'd5, 32'h1); check_all();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

endmodule